// File: doc/BRIEF.md
# PHY Management Register File with Banked Indirect Window

This block is the management register space of a PHY. A simple parallel register port (5-bit address, 16-bit write data, write and read strobes, registered read data) reaches 32 directly addressed 16-bit registers. The direct space holds a self-clearing soft-reset bit, a masked interrupt source register that clears on read, an interrupt output, and general-purpose storage.

A three-register window inside the direct space reaches up to eight banks of extended registers. To write an extended location, software first loads the staging write-data register. It then writes the window control word with the write command, a 3-bit bank and an 8-bit offset. To read one, software writes the control word with the read command and then reads the fetched value from the read-data register. Bank 0 mirrors the direct space. Banks 1 to 3 are separate 32-word stores. The transfer completes on the edge of the control write, so the next port access always sees the result.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After rst_ni is released, every direct register reads 0 and irq_o is low.
- R2: A read strobe at address A makes rdata_o hold A's value from the next clock edge. Without a read strobe rdata_o keeps its value. The general-purpose registers store all 16 written bits.
- R3: The window control register sits at address 0x14. Bits 10:8 (bank) and 7:0 (offset) are stored and read back. Bits 15:11 always read 0, including the command bits 12 (read) and 11 (write).
- R4: A control write with bit 11 set and bit 12 clear copies the staging register at 0x16 into the selected bank and offset.
- R5: A control write with bit 12 set and bit 11 clear loads the selected location into the read-data register at 0x15. Bank 0 maps offsets 0 to 31 onto the direct registers. A bank-0 read has no clear-on-read side effect. A bank-0 write acts as a direct write, except at the window addresses 0x14 to 0x16, which it leaves unchanged.
- R6: A control write with both bit 12 and bit 11 set transfers nothing. The read-data register and every bank location stay unchanged.
- R7: Banks 1, 2 and 3 each hold 32 independent words. An offset of 32 or more, or a bank of 4 to 7, reads 0 and ignores writes. Such an offset never wraps onto a lower one.
- R8: Writing 1 to bit 15 of address 0x00 starts a soft reset. While it runs, that bit reads 1. It clears itself after SRST_CYCLES clocks, and a later read sees 0. The soft reset zeroes the general-purpose registers, the mask, the sources and all extended banks, and writes to these are ignored while it runs. The registers at 0x14, 0x15 and 0x16 keep their values.
- R9: Bit i of the source register at 0x18 is set on a rising edge of evt_i[i]. A held level sets it only once. A read of 0x18 returns the current bits and then clears them. An edge in the same cycle as the clearing read stays set.
- R10: The mask register at 0x19 stores bits 14:0, and bit 15 reads 0. irq_o is high exactly when some source bit is set and its mask bit is 1. Bit 2 is the link-up event and bit 1 the link-down event.
- R11: Writes to 0x15 and 0x18 through the port have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Direct register address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| re_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 16 | Read data, valid the cycle after re_i |
| evt_i | input | 15 | Interrupt event inputs, rising-edge sensitive (bit 2 link-up, bit 1 link-down) |
| irq_o | output | 1 | Interrupt request |

## Verification
The window is driven with the same offset in each of the three implemented banks. This separates real per-bank storage from a shared store. The bench also probes offset 31, offset 40 (which would alias offset 8 if only the low address bits were decoded) and an unimplemented bank. Bank-0 accesses are compared against direct accesses to the same register, including the mask, the source register and the staging register. These comparisons tell a true alias apart from a copy, and a window-protected target from a writable one. Control words with both command bits set, with the high bits set, and issued during a soft reset show which state each command may touch. Event pulses, held levels and an edge that coincides with a clearing read separate edge detection and the set-over-clear priority from level capture.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned DIR_AW   = 5;
  localparam int unsigned DIR_REGS = 1 << DIR_AW;
  localparam int unsigned SEL_W    = 11;

  localparam logic [DIR_AW-1:0] A_CTRL = 5'h00;
  localparam logic [DIR_AW-1:0] A_WCTL = 5'h14;
  localparam logic [DIR_AW-1:0] A_WRD  = 5'h15;
  localparam logic [DIR_AW-1:0] A_WWR  = 5'h16;
  localparam logic [DIR_AW-1:0] A_ISRC = 5'h18;
  localparam logic [DIR_AW-1:0] A_IMSK = 5'h19;

  localparam int unsigned CMD_RD_BIT = 12;
  localparam int unsigned CMD_WR_BIT = 11;
  localparam int unsigned SRST_BIT   = 15;

  typedef struct packed {
    logic [2:0] bank;
    logic [7:0] off;
  } win_sel_t;

  function automatic logic is_window(logic [DIR_AW-1:0] a);
    return (a == A_WCTL) || (a == A_WRD) || (a == A_WWR);
  endfunction

  function automatic logic is_plain(logic [DIR_AW-1:0] a);
    return !(is_window(a) || (a == A_ISRC) || (a == A_IMSK));
  endfunction
endpackage

// File: rtl/mgmt_ext_bank.sv
module mgmt_ext_bank
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned WORDS = 32,
  localparam int unsigned AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o
);
  logic [REG_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];

  // R8: a cleared bank reads zero anywhere on the following cycle
  p_bank_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rdata_o == '0));
endmodule

// File: rtl/mgmt_irq.sv
module mgmt_irq #(
  parameter int unsigned NUM_SRC = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               rd_clr_i,
  input  logic               msk_we_i,
  input  logic [NUM_SRC-1:0] msk_wdata_i,
  output logic [NUM_SRC-1:0] src_o,
  output logic [NUM_SRC-1:0] msk_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] evt_q, src_q, msk_q, rise;

  assign rise = evt_i & ~evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      src_q <= '0;
      msk_q <= '0;
    end else begin
      evt_q <= evt_i;
      if (clr_i) begin
        src_q <= '0;
        msk_q <= '0;
      end else begin
        // new edges win over the clearing read
        src_q <= (rd_clr_i ? '0 : src_q) | rise;
        if (msk_we_i) msk_q <= msk_wdata_i;
      end
    end
  end

  assign src_o = src_q;
  assign msk_o = msk_q;
  assign irq_o = |(src_q & msk_q);

  p_srst_irq_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (src_o == '0 && msk_o == '0));

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (|rise) |=> ((src_o & $past(rise)) == $past(rise)));

  p_cor_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (rd_clr_i && !(|rise)) |=> (src_o == '0));
endmodule

// File: rtl/mgmt_srst.sv
module mgmt_srst #(
  parameter int unsigned CYCLES = 16,
  localparam int unsigned CW = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  p_srst_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_o);

  p_srst_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(start_i));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 15,
  parameter int unsigned BANK_WORDS  = 32,
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned IMPL_BANKS  = 3,
  parameter int unsigned SRST_CYCLES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIR_AW-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic               irq_o
);
  localparam int unsigned WORD_AW = (BANK_WORDS > 1) ? $clog2(BANK_WORDS) : 1;
  localparam int unsigned PAD_SRC = REG_W - NUM_SRC;
  localparam int unsigned PAD_SEL = REG_W - SEL_W;

  win_sel_t         cmd_sel;
  logic             ctl_we, cmd_rd, cmd_wr, dir_ok, ext_ok;
  logic             alias_we, u_we, srst_act, srst_start;
  logic [DIR_AW-1:0] u_addr;
  logic [REG_W-1:0] u_data, ind_val, rdata_q;
  logic [SEL_W-1:0] ctl_q;
  logic [REG_W-1:0] rd_q, wr_q;
  logic [NUM_SRC-1:0] src, msk;
  logic [REG_W-1:0] gen_q    [DIR_REGS];
  logic [REG_W-1:0] dir_view [DIR_REGS];
  logic [REG_W-1:0] ext_rd   [NUM_BANKS];

  // window command decode
  assign cmd_sel = win_sel_t'(wdata_i[SEL_W-1:0]);
  assign ctl_we  = we_i && (addr_i == A_WCTL);
  assign cmd_rd  = ctl_we && wdata_i[CMD_RD_BIT] && !wdata_i[CMD_WR_BIT];
  assign cmd_wr  = ctl_we && wdata_i[CMD_WR_BIT] && !wdata_i[CMD_RD_BIT];
  assign dir_ok  = 32'(cmd_sel.off) < DIR_REGS;
  assign ext_ok  = 32'(cmd_sel.off) < BANK_WORDS;

  assign alias_we = cmd_wr && (cmd_sel.bank == 3'd0) && dir_ok &&
                    !is_window(cmd_sel.off[DIR_AW-1:0]);

  // unified write into the direct space: port write or bank-0 alias
  always_comb begin
    if (alias_we) begin
      u_we   = 1'b1;
      u_addr = cmd_sel.off[DIR_AW-1:0];
      u_data = wr_q;
    end else begin
      u_we   = we_i && !is_window(addr_i);
      u_addr = addr_i;
      u_data = wdata_i;
    end
  end

  assign srst_start = u_we && (u_addr == A_CTRL) && u_data[SRST_BIT];

  mgmt_srst #(.CYCLES(SRST_CYCLES)) u_srst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (srst_start),
    .active_o (srst_act)
  );

  mgmt_irq #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (srst_act),
    .evt_i       (evt_i),
    .rd_clr_i    (re_i && (addr_i == A_ISRC)),
    .msk_we_i    (u_we && (u_addr == A_IMSK)),
    .msk_wdata_i (u_data[NUM_SRC-1:0]),
    .src_o       (src),
    .msk_o       (msk),
    .irq_o       (irq_o)
  );

  // general-purpose direct registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DIR_REGS; i++) gen_q[i] <= '0;
    end else if (srst_act) begin
      for (int i = 0; i < DIR_REGS; i++) gen_q[i] <= '0;
    end else if (u_we && is_plain(u_addr)) begin
      gen_q[u_addr] <= u_data;
    end
  end

  // window staging registers, untouched by soft reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
    end else begin
      if (ctl_we) ctl_q <= wdata_i[SEL_W-1:0] & ~(SEL_W'(1) << CMD_WR_BIT);
      if (we_i && (addr_i == A_WWR)) wr_q <= wdata_i;
      if (cmd_rd) rd_q <= ind_val;
    end
  end

  always_comb begin
    for (int i = 0; i < DIR_REGS; i++) begin
      case (DIR_AW'(i))
        A_CTRL:  dir_view[i] = {srst_act, gen_q[i][REG_W-2:0]};
        A_WCTL:  dir_view[i] = {{PAD_SEL{1'b0}}, ctl_q};
        A_WRD:   dir_view[i] = rd_q;
        A_WWR:   dir_view[i] = wr_q;
        A_ISRC:  dir_view[i] = {{PAD_SRC{1'b0}}, src};
        A_IMSK:  dir_view[i] = {{PAD_SRC{1'b0}}, msk};
        default: dir_view[i] = gen_q[i];
      endcase
    end
  end

  // extended banks
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    if (b >= 1 && b <= IMPL_BANKS) begin : g_impl
      mgmt_ext_bank #(.WORDS(BANK_WORDS)) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (srst_act),
        .we_i    (cmd_wr && !srst_act && ext_ok && (cmd_sel.bank == 3'(b))),
        .addr_i  (cmd_sel.off[WORD_AW-1:0]),
        .wdata_i (wr_q),
        .rdata_o (ext_rd[b])
      );
    end else begin : g_none
      assign ext_rd[b] = '0;
    end
  end

  always_comb begin
    ind_val = '0;
    if (cmd_sel.bank == 3'd0) begin
      if (dir_ok) ind_val = dir_view[cmd_sel.off[DIR_AW-1:0]];
    end else if (ext_ok) begin
      ind_val = ext_rd[cmd_sel.bank];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= dir_view[addr_i];
  end
  assign rdata_o = rdata_q;

  p_rd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  p_both_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we && wdata_i[CMD_RD_BIT] && wdata_i[CMD_WR_BIT]) |=> $stable(rd_q));

  p_stage_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_act && !(we_i && addr_i == A_WWR)) |=> $stable(wr_q));
endmodule

// File: tb/phy_mgmt_regs_tb.sv
module phy_mgmt_regs_tb_top;
  localparam int unsigned SRST = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] rdata;
  logic [14:0] evt = '0;
  logic        irq;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  phy_mgmt_regs #(.SRST_CYCLES(SRST)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; v = rdata;
  endtask

  task automatic ind_wr(input logic [2:0] b, input logic [7:0] o, input logic [15:0] d);
    wr(5'h16, d);
    wr(5'h14, 16'h0800 | {5'b0, b, o});
  endtask

  task automatic ind_rd(input logic [2:0] b, input logic [7:0] o, output logic [15:0] v);
    wr(5'h14, 16'h1000 | {5'b0, b, o});
    rd(5'h15, v);
  endtask

  task automatic pulse(input int bitn);
    @(negedge clk); evt[bitn] = 1'b1;
    @(negedge clk); evt[bitn] = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 irq", {15'b0, irq}, 16'h0);
    foreach (dut_addrs[k]) begin
      rd(dut_addrs[k], v);
      chk($sformatf("R1 addr %h", dut_addrs[k]), v, 16'h0);
    end
  endtask
  logic [4:0] dut_addrs [7] = '{5'h00, 5'h03, 5'h14, 5'h15, 5'h16, 5'h18, 5'h19};

  task automatic t_direct();
    logic [15:0] v;
    wr(5'h03, 16'hA5A5); wr(5'h1F, 16'h1234);
    rd(5'h03, v); chk("R2 reg03", v, 16'hA5A5);
    rd(5'h1F, v); chk("R2 reg1F", v, 16'h1234);
    repeat (3) @(negedge clk);
    chk("R2 hold", rdata, 16'h1234);
    wr(5'h15, 16'hFFFF); rd(5'h15, v); chk("R11 rd-data ro", v, 16'h0000);
    wr(5'h18, 16'hFFFF); rd(5'h18, v); chk("R11 source ro", v, 16'h0000);
  endtask

  task automatic t_ctl();
    logic [15:0] v;
    wr(5'h14, 16'hFF22); rd(5'h14, v); chk("R3 ctl high bits", v, 16'h0722);
    wr(5'h14, 16'h1305); rd(5'h14, v); chk("R3 ctl rd bit", v, 16'h0305);
    wr(5'h14, 16'h0A01); rd(5'h14, v); chk("R3 ctl wr bit", v, 16'h0201);
  endtask

  task automatic t_banks();
    logic [15:0] v;
    ind_wr(3'd1, 8'd7, 16'h1111);
    ind_wr(3'd2, 8'd7, 16'h2222);
    ind_wr(3'd3, 8'd7, 16'h3333);
    ind_rd(3'd1, 8'd7, v); chk("R4 bank1", v, 16'h1111);
    ind_rd(3'd2, 8'd7, v); chk("R4 bank2", v, 16'h2222);
    ind_rd(3'd3, 8'd7, v); chk("R7 bank3 separate", v, 16'h3333);
    ind_wr(3'd3, 8'd31, 16'h3131);
    ind_rd(3'd3, 8'd31, v); chk("R7 last offset", v, 16'h3131);
    rd(5'h16, v); chk("R4 staging kept", v, 16'h3131);
  endtask

  task automatic t_range();
    logic [15:0] v;
    ind_wr(3'd5, 8'd3, 16'h5555);
    ind_rd(3'd5, 8'd3, v); chk("R7 bank5", v, 16'h0000);
    ind_wr(3'd1, 8'd40, 16'h6666);
    ind_rd(3'd1, 8'd40, v); chk("R7 off40", v, 16'h0000);
    ind_rd(3'd1, 8'd8, v);  chk("R7 no wrap", v, 16'h0000);
  endtask

  task automatic t_both();
    logic [15:0] v;
    ind_wr(3'd1, 8'd2, 16'h2424);
    ind_rd(3'd1, 8'd2, v); chk("R5 ext read", v, 16'h2424);
    wr(5'h16, 16'h9999);
    wr(5'h14, 16'h1903);
    rd(5'h15, v); chk("R6 rd-data kept", v, 16'h2424);
    ind_rd(3'd1, 8'd3, v); chk("R6 no write", v, 16'h0000);
  endtask

  task automatic t_bank0();
    logic [15:0] v;
    ind_wr(3'd0, 8'd5, 16'h4242);
    rd(5'h05, v); chk("R5 alias write", v, 16'h4242);
    wr(5'h06, 16'h7777);
    ind_rd(3'd0, 8'd6, v); chk("R5 alias read", v, 16'h7777);
    ind_wr(3'd0, 8'h19, 16'h8003);
    rd(5'h19, v); chk("R10 mask via alias", v, 16'h0003);
    wr(5'h19, 16'h0000);
    wr(5'h16, 16'h1111);
    wr(5'h14, 16'h0816);
    rd(5'h16, v); chk("R5 window protected", v, 16'h1111);
    pulse(4);
    ind_rd(3'd0, 8'h18, v); chk("R5 alias src", v, 16'h0010);
    rd(5'h18, v); chk("R5 no side clear", v, 16'h0010);
    rd(5'h18, v); chk("R9 cleared", v, 16'h0000);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    wr(5'h19, 16'hFFFF); rd(5'h19, v); chk("R10 mask bits", v, 16'h7FFF);
    wr(5'h19, 16'h0004);
    pulse(1); chk("R10 masked down", {15'b0, irq}, 16'h0);
    pulse(2); chk("R10 link-up irq", {15'b0, irq}, 16'h1);
    rd(5'h18, v); chk("R9 both latched", v, 16'h0006);
    @(negedge clk); chk("R10 irq after clear", {15'b0, irq}, 16'h0);
    rd(5'h18, v); chk("R9 clear on read", v, 16'h0000);
    @(negedge clk); evt[2] = 1'b1;
    repeat (3) @(negedge clk);
    rd(5'h18, v); chk("R9 level once", v, 16'h0004);
    rd(5'h18, v); chk("R9 level no reset", v, 16'h0000);
    evt[2] = 1'b0;
    pulse(5);
    @(negedge clk); addr = 5'h18; re = 1'b1; evt[3] = 1'b1;
    @(negedge clk); re = 1'b0; evt[3] = 1'b0; v = rdata;
    chk("R9 pre-clear value", v, 16'h0020);
    rd(5'h18, v); chk("R9 set wins", v, 16'h0008);
  endtask

  task automatic t_srst();
    logic [15:0] v;
    wr(5'h03, 16'h3C3C);
    ind_wr(3'd2, 8'd1, 16'hABCD);
    wr(5'h19, 16'h0006);
    pulse(1);
    chk("R10 irq set", {15'b0, irq}, 16'h1);
    wr(5'h16, 16'hBEEF);
    wr(5'h00, 16'h8000);
    rd(5'h00, v); chk("R8 busy bit", v, 16'h8000);
    wr(5'h19, 16'h0001);
    repeat (SRST + 4) @(negedge clk);
    rd(5'h00, v); chk("R8 self clear", v, 16'h0000);
    rd(5'h03, v); chk("R8 gp cleared", v, 16'h0000);
    rd(5'h19, v); chk("R8 mask cleared", v, 16'h0000);
    rd(5'h18, v); chk("R8 source cleared", v, 16'h0000);
    chk("R8 irq low", {15'b0, irq}, 16'h0);
    rd(5'h16, v); chk("R8 staging kept", v, 16'hBEEF);
    rd(5'h14, v); chk("R8 ctl kept", v, 16'h0201);
    ind_rd(3'd2, 8'd1, v); chk("R8 bank cleared", v, 16'h0000);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_ctl();
    t_banks();
    t_range();
    t_both();
    t_bank0();
    t_irq();
    t_srst();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all act=running exp=finished");
      summary();
      $finish;
    end
  end
endmodule